// File: doc/BRIEF.md
# Exclusive Access Monitor with Shared Memory

This block sits in front of a small single-ported memory that several bus masters share. Each request carries a master ID. The block tracks load-exclusive and store-exclusive pairs so that software spin locks built on these pairs behave correctly. An exclusive read records a reservation, which is the pair of master ID and word address. An exclusive write then commits only if that reservation is still intact. A committed exclusive write is reported with an exclusive-okay indication. A refused exclusive write leaves memory untouched and reports a plain okay.

Requests are accepted one per cycle on a simple valid-qualified interface. No handshake back-pressure is used. Each response appears one cycle after its request. The parameter `PER_MASTER` selects how reservations are stored:

- When it is 1, each master has its own reservation slot. Interleaved read/read/write/write races then resolve to the first writer.
- When it is 0, a single shared slot holds only the most recent exclusive reader. The last master to read wins instead.

Top module: `exmon`

## Requirements
- R1: Every cycle with `req_valid` high is answered by `rsp_valid` high on the next cycle. Every cycle without a request gives `rsp_valid` low on the next cycle. `rsp_rdata` carries the addressed word for reads and zero for writes.
- R2: `rsp_exokay` = 1 means exclusive-okay and 0 means okay. An exclusive read (`req_excl`=1, `req_write`=0) answers 1 and records a reservation. Plain reads and plain writes always answer 0.
- R3: An exclusive write succeeds (answers 1, memory updated) only when the writing master holds a valid reservation on the same address.
- R4: A refused exclusive write answers 0 and leaves the memory word unchanged.
- R5: Any exclusive write, whether it succeeds or fails, drops the writer's own reservation, so a second exclusive write without a fresh exclusive read fails.
- R6: A committed write, plain or exclusive, clears every reservation on that address. A lock released by a plain store therefore makes stale exclusive writes fail.
- R7: Plain reads, and plain writes to other addresses, between an exclusive read and its exclusive write leave the reservation intact.
- R8: A new exclusive read from a master replaces that master's earlier reservation. An exclusive write to the old address then fails.
- R9: With `PER_MASTER`=1, the order read-A, read-B, write-A, write-B to one address lets A succeed and makes B fail.
- R10: With `PER_MASTER`=0, only the latest exclusive reader is held. The same order makes A fail and lets B succeed.
- R11: Reset clears all reservations, holds `rsp_valid` low and zeroes the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | 1 = exclusive access |
| req_id | input | ID_W | Issuing master |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_exokay | output | 1 | 1 = exclusive-okay, 0 = okay |
| rsp_rdata | output | DATA_W | Read data, zero for writes |

## Verification
The bench goes after the following races and the faults each one exposes:

- **Two masters interleaving on one lock word, in both storage modes.** A monitor that fails to clear other masters' reservations on a commit would let both masters take the lock. A shared-slot build that compares only addresses would let the wrong master win.
- **A repeated exclusive write.** A monitor that keeps the reservation after a store-exclusive would grant the lock twice.
- **A mismatched address and a replaced reservation.** A monitor that ignores the address would commit to the wrong word.
- **Reservations that must survive.** Plain traffic to other words and plain reads must not cancel a reservation. Over-eager clearing shows up there as a lock that can never be taken.

// File: rtl/exmon.sv
module exmon #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter bit PER_MASTER  = 1'b1,
  localparam int ID_W  = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NSLOT = PER_MASTER ? NUM_MASTERS : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_excl,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_exokay,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NSLOT-1:0]  res_vld;
  logic [ADDR_W-1:0] res_addr [NSLOT];
  logic [ID_W-1:0]   res_id [NSLOT];
  logic [NSLOT-1:0]  hit;

  wire ex_rd  = req_valid && !req_write && req_excl;
  wire ex_wr  = req_valid && req_write && req_excl;
  wire ex_ok  = ex_wr && (|hit);
  wire commit = req_valid && req_write && (!req_excl || ex_ok);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire owner = PER_MASTER ? (req_id == ID_W'(g)) : (res_id[g] == req_id);
    wire taker = PER_MASTER ? (req_id == ID_W'(g)) : 1'b1;

    assign hit[g] = res_vld[g] && owner && (res_addr[g] == req_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_vld[g]  <= 1'b0;
        res_addr[g] <= '0;
        res_id[g]   <= '0;
      end else if (ex_rd && taker) begin
        res_vld[g]  <= 1'b1;
        res_addr[g] <= req_addr;
        res_id[g]   <= req_id;
      end else if ((ex_wr && owner) || (commit && res_addr[g] == req_addr)) begin
        res_vld[g]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_exokay <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_exokay <= ex_rd || ex_ok;
      rsp_rdata  <= (req_valid && !req_write) ? mem[req_addr] : '0;
    end
  end

endmodule

module exmon_chk #(
  parameter int NSLOT  = 4,
  parameter int ID_W   = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_excl,
  input logic [NSLOT-1:0]  res_vld,
  input logic              rsp_valid,
  input logic              rsp_exokay,
  input logic [DATA_W-1:0] rsp_rdata
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R1
  write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));

  // R2
  plain_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_excl) |=> !rsp_exokay);

  // R2
  exrd_exokay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_excl && !req_write) |=> rsp_exokay);

  // R3
  no_resv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_excl && res_vld == '0) |=> !rsp_exokay);

  // R2
  exokay_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exokay |-> rsp_valid);

endmodule

bind exmon exmon_chk #(.NSLOT(NSLOT), .ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_excl(req_excl), .res_vld(res_vld), .rsp_valid(rsp_valid),
  .rsp_exokay(rsp_exokay), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_exmon.sv
module tb_exmon;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
  logic [1:0]  req_id = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_exokay, s_valid, s_exokay;
  logic [31:0] rsp_rdata, s_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  exmon dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_exokay(rsp_exokay), .rsp_rdata(rsp_rdata)
  );

  exmon #(.PER_MASTER(1'b0)) dut_single (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(s_valid), .rsp_exokay(s_exokay), .rsp_rdata(s_rdata)
  );

  // tag[79:76] valid wr ex id[1:0] addr[5:0] wdata[31:0] exp_ex rdata[31:0]
  function automatic logic [79:0] mk(input logic [3:0] tag, input logic v, input logic w,
      input logic x, input logic [1:0] id, input logic [5:0] a, input logic [31:0] d,
      input logic xo, input logic [31:0] rd);
    return {tag, v, w, x, id, a, d, xo, rd};
  endfunction

  localparam int NV = 27;
  localparam logic [79:0] VEC [NV] = '{
    mk(4'd11, 1, 1, 1, 0,  5, 9, 0, 0),  // R11 no reservation after reset
    mk(4'd4,  1, 0, 0, 0,  5, 0, 0, 0),  // R4 memory unchanged
    mk(4'd2,  1, 0, 1, 0,  5, 0, 1, 0),  // R2 exclusive read A
    mk(4'd9,  1, 0, 1, 1,  5, 0, 1, 0),  // R9 exclusive read B
    mk(4'd9,  1, 1, 1, 0,  5, 1, 1, 0),  // R9 A wins
    mk(4'd9,  1, 1, 1, 1,  5, 2, 0, 0),  // R9 B refused
    mk(4'd4,  1, 0, 0, 2,  5, 0, 0, 1),  // R4 B did not write
    mk(4'd5,  1, 1, 1, 0,  5, 3, 0, 0),  // R5 repeat write fails
    mk(4'd5,  1, 0, 0, 2,  5, 0, 0, 1),  // R5 memory kept
    mk(4'd2,  1, 0, 1, 1,  5, 0, 1, 1),  // R2 exclusive read B
    mk(4'd7,  1, 0, 0, 0,  7, 0, 0, 0),  // R7 plain read elsewhere
    mk(4'd7,  1, 1, 0, 0,  9, 7, 0, 0),  // R7 plain write elsewhere
    mk(4'd7,  1, 1, 1, 1,  5, 4, 1, 0),  // R7 reservation survived
    mk(4'd2,  1, 0, 1, 0,  5, 0, 1, 4),  // R2 exclusive read A
    mk(4'd6,  1, 1, 0, 2,  5, 0, 0, 0),  // R6 plain release store
    mk(4'd6,  1, 1, 1, 0,  5, 8, 0, 0),  // R6 stale write refused
    mk(4'd6,  1, 0, 0, 3,  5, 0, 0, 0),  // R6 memory kept
    mk(4'd2,  1, 0, 1, 0,  6, 0, 1, 0),  // R2 read A at 6
    mk(4'd3,  1, 1, 1, 0,  5, 9, 0, 0),  // R3 address mismatch
    mk(4'd3,  1, 0, 0, 0,  5, 0, 0, 0),  // R3 memory kept
    mk(4'd8,  1, 0, 1, 2, 10, 0, 1, 0),  // R8 read C at 10
    mk(4'd8,  1, 0, 1, 2, 11, 0, 1, 0),  // R8 replace with 11
    mk(4'd8,  1, 1, 1, 2, 10, 5, 0, 0),  // R8 old address fails
    mk(4'd2,  1, 0, 1, 2, 11, 0, 1, 0),  // R2 re-read C at 11
    mk(4'd3,  1, 1, 1, 2, 11, 6, 1, 0),  // R3 commit
    mk(4'd1,  1, 0, 0, 1, 11, 0, 0, 6),  // R1 read data
    mk(4'd1,  0, 0, 0, 0,  0, 0, 0, 0)   // R1 idle cycle
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic x, input logic [1:0] id,
      input logic [5:0] a, input logic [31:0] d);
    req_valid = v; req_write = w; req_excl = x; req_id = id; req_addr = a; req_wdata = d;
  endtask

  task automatic check_vec(input int k);
    logic [79:0] e;
    e = VEC[k];
    chk($sformatf("R%0d vec%0d valid", e[79:76], k), {63'd0, rsp_valid}, {63'd0, e[75]});
    chk($sformatf("R%0d vec%0d exokay", e[79:76], k), {63'd0, rsp_exokay}, {63'd0, e[32]});
    chk($sformatf("R%0d vec%0d rdata", e[79:76], k), {32'd0, rsp_rdata}, {32'd0, e[31:0]});
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R11 reset rdata", {32'd0, rsp_rdata}, 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][75], VEC[k][74], VEC[k][73], VEC[k][72:71], VEC[k][70:65], VEC[k][64:33]);
      @(negedge clk);
      check_vec(k);
    end

    // R11 reservation lost across reset
    drive(1, 0, 1, 0, 2, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    drive(1, 1, 1, 0, 2, 5);
    @(negedge clk);
    chk("R11 exclusive write after reset", {63'd0, rsp_exokay}, 64'd0);
    drive(1, 0, 0, 0, 11, 0);
    @(negedge clk);
    chk("R11 memory zeroed", {32'd0, rsp_rdata}, 64'd0);

    // R10 shared-slot race: read-A, read-B, write-A, write-B
    drive(1, 0, 1, 0, 20, 0);
    @(negedge clk);
    chk("R10 single read A", {63'd0, s_exokay}, 64'd1);
    drive(1, 0, 1, 1, 20, 0);
    @(negedge clk);
    chk("R10 single read B", {63'd0, s_exokay}, 64'd1);
    drive(1, 1, 1, 0, 20, 1);
    @(negedge clk);
    chk("R10 single write A fails", {63'd0, s_exokay}, 64'd0);
    chk("R9 per-master write A wins", {63'd0, rsp_exokay}, 64'd1);
    drive(1, 1, 1, 1, 20, 2);
    @(negedge clk);
    chk("R10 single write B wins", {63'd0, s_exokay}, 64'd1);
    chk("R9 per-master write B fails", {63'd0, rsp_exokay}, 64'd0);
    drive(1, 0, 0, 3, 20, 0);
    @(negedge clk);
    chk("R10 single memory holds B data", {32'd0, s_rdata}, 64'd2);
    chk("R9 per-master memory holds A data", {32'd0, rsp_rdata}, 64'd1);
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule